// File: doc/BRIEF.md
# Next-Instruction-Address Unit with Return Stack

This block owns the program counter of a small processor. Every clock it chooses the next instruction address from a command code. It can step to the next instruction, jump, take or skip a flag-conditioned branch, call a subroutine, return from one, or halt. Subroutine return addresses are kept in a dedicated last-in-first-out stack inside the block, so nested calls need no data memory.

The decoder outside presents a 3-bit command, a 10-bit target and a 2-bit condition selector each cycle, together with the zero and carry flags from the ALU. The block drives the PC, a halted indication, and two sticky flags that report misuse of the return stack. A call that finds the stack full raises one flag. A return that finds it empty raises the other. Instruction fetch and decode sit outside the block.

Top module: `nia_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, `pc_o` is 0, `halted_o`, `stk_ovf_o` and `stk_unf_o` are 0, and the return stack is empty, so a return issued after reset reports underflow.
- R2: Command 0 (step) and the unused codes 6 and 7 set the PC to PC+1 on the next edge, wrapping from 1023 to 0.
- R3: Command 1 (jump) loads `tgt_i` into the PC on the next edge.
- R4: Command 2 (branch) loads `tgt_i` when its condition holds and otherwise steps to PC+1. The condition holds when the zero flag is set for `cond_i`=00, when the zero flag is clear for 01, when the carry flag is set for 10, and when the carry flag is clear for 11.
- R5: Command 3 (call) pushes PC+1 onto the return stack and loads `tgt_i` into the PC.
- R6: Command 4 (return) pops the most recently pushed address into the PC, in last-in-first-out order.
- R7: Command 5 (halt) sets `halted_o` and holds the PC at its current value. While halted, every command is ignored and PC, stack and flags stay frozen until reset.
- R8: A call issued with 16 entries already on the stack sets the sticky `stk_ovf_o`, leaves the stack contents unchanged and steps the PC to PC+1.
- R9: A return issued with an empty stack sets the sticky `stk_unf_o` and steps the PC to PC+1.
- R10: Sixteen nested calls all fit, and the following sixteen returns deliver each pushed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Next-address command: 0 step, 1 jump, 2 branch, 3 call, 4 return, 5 halt |
| tgt_i | input | 10 | Target address for jump, branch and call |
| cond_i | input | 2 | Branch condition selector |
| flag_z_i | input | 1 | Zero flag from the ALU |
| flag_c_i | input | 1 | Carry flag from the ALU |
| pc_o | output | 10 | Current program counter |
| halted_o | output | 1 | Processor halted |
| stk_ovf_o | output | 1 | Sticky: a call found the return stack full |
| stk_unf_o | output | 1 | Sticky: a return found the return stack empty |

## Verification
The bench runs all four branch conditions with the selected flag both set and clear. A design with swapped or inverted condition encodings would branch when it should fall through, or the reverse. It nests sixteen calls, then makes a seventeenth. An off-by-one in the full test would either reject the sixteenth call or overwrite the top entry, and the returns that follow would then come back in the wrong order. It drains the stack one step past empty and looks for the underflow flag and a plain PC increment. A faulty design would instead load a stale entry. It also issues jumps, calls and steps after a halt and after the PC wraps from 1023, where a design that leaks a command through the halt or forgets to wrap would produce a different address.

// File: rtl/nia_pkg.sv
package nia_pkg;

   localparam int CMD_W  = 3;
   localparam int COND_W = 2;

   typedef enum logic [CMD_W-1:0] {
      CMD_STEP   = 3'd0,
      CMD_JUMP   = 3'd1,
      CMD_BRANCH = 3'd2,
      CMD_CALL   = 3'd3,
      CMD_RET    = 3'd4,
      CMD_HALT   = 3'd5
   } nia_cmd_e;

   typedef enum logic [COND_W-1:0] {
      COND_ZSET = 2'b00,
      COND_ZCLR = 2'b01,
      COND_CSET = 2'b10,
      COND_CCLR = 2'b11
   } nia_cond_e;

endpackage

// File: rtl/nia_cond_eval.sv
module nia_cond_eval
   import nia_pkg::*;
(
   input  logic [COND_W-1:0] cond_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   output logic              take_o
);

   logic sel_flag;

   // Upper bit picks the flag, lower bit inverts the test
   always_comb begin
      sel_flag = cond_i[1] ? flag_c_i : flag_z_i;
      take_o   = cond_i[0] ? ~sel_flag : sel_flag;
   end

endmodule

// File: rtl/nia_ret_stack.sv
module nia_ret_stack #(
   parameter int AW        = 10,
   parameter int DEPTH     = 16,
   parameter bit CLEAR_MEM = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] push_data_i,
   output logic [AW-1:0] top_o,
   output logic          full_o,
   output logic          empty_o
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;
   logic [AW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push_i && !full_o) begin
         cnt_q <= cnt_q + CW'(1);
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   // One write port per entry; the variant decides whether storage is reset
   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      if (CLEAR_MEM) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_q[g] <= '0;
            end else if (push_i && !full_o && cnt_q == CW'(g)) begin
               mem_q[g] <= push_data_i;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (rst_n && push_i && !full_o && cnt_q == CW'(g)) begin
               mem_q[g] <= push_data_i;
            end
         end
      end
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CW'(i + 1)) top_o = mem_q[i];
      end
   end

   assign full_o  = (cnt_q == CW'(DEPTH));
   assign empty_o = (cnt_q == '0);

   // R8: the selector never pushes into a full stack
   p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);

   // R9: the selector never pops an empty stack
   p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i);

   // R10: occupancy never exceeds the depth
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R8: a full stack that is not popped stays full
   p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !pop_i) |=> full_o);

endmodule

// File: rtl/nia_next_sel.sv
module nia_next_sel
   import nia_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [AW-1:0]    pc_i,
   input  logic [AW-1:0]    tgt_i,
   input  logic             halted_i,
   input  logic             take_i,
   input  logic             stk_full_i,
   input  logic             stk_empty_i,
   input  logic [AW-1:0]    stk_top_i,
   output logic [AW-1:0]    next_pc_o,
   output logic [AW-1:0]    ret_addr_o,
   output logic             push_o,
   output logic             pop_o,
   output logic             set_halt_o,
   output logic             set_ovf_o,
   output logic             set_unf_o
);

   logic [AW-1:0] pc_inc;

   assign pc_inc     = pc_i + AW'(1);
   assign ret_addr_o = pc_inc;

   always_comb begin
      next_pc_o  = pc_inc;
      push_o     = 1'b0;
      pop_o      = 1'b0;
      set_halt_o = 1'b0;
      set_ovf_o  = 1'b0;
      set_unf_o  = 1'b0;
      if (halted_i) begin
         next_pc_o = pc_i;
      end else begin
         case (cmd_i)
            CMD_JUMP:   next_pc_o = tgt_i;
            CMD_BRANCH: next_pc_o = take_i ? tgt_i : pc_inc;
            CMD_CALL: begin
               if (stk_full_i) begin
                  set_ovf_o = 1'b1;
               end else begin
                  push_o    = 1'b1;
                  next_pc_o = tgt_i;
               end
            end
            CMD_RET: begin
               if (stk_empty_i) begin
                  set_unf_o = 1'b1;
               end else begin
                  pop_o     = 1'b1;
                  next_pc_o = stk_top_i;
               end
            end
            CMD_HALT: begin
               set_halt_o = 1'b1;
               next_pc_o  = pc_i;
            end
            default: next_pc_o = pc_inc;
         endcase
      end
   end

endmodule

// File: rtl/nia_unit.sv
module nia_unit
   import nia_pkg::*;
#(
   parameter int AW              = 10,
   parameter int DEPTH           = 16,
   parameter bit CLEAR_STACK_MEM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [AW-1:0]    tgt_i,
   input  logic [COND_W-1:0] cond_i,
   input  logic             flag_z_i,
   input  logic             flag_c_i,
   output logic [AW-1:0]    pc_o,
   output logic             halted_o,
   output logic             stk_ovf_o,
   output logic             stk_unf_o
);

   if (AW < 2) begin : g_bad_aw
      $error("nia_unit: AW must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("nia_unit: DEPTH must be at least 2");
   end

   logic [AW-1:0] pc_q, next_pc, ret_addr, stk_top;
   logic          halted_q, ovf_q, unf_q;
   logic          take, push, pop, set_halt, set_ovf, set_unf;
   logic          stk_full, stk_empty;

   nia_cond_eval u_cond (
      .cond_i   (cond_i),
      .flag_z_i (flag_z_i),
      .flag_c_i (flag_c_i),
      .take_o   (take)
   );

   nia_next_sel #(.AW(AW)) u_sel (
      .cmd_i       (cmd_i),
      .pc_i        (pc_q),
      .tgt_i       (tgt_i),
      .halted_i    (halted_q),
      .take_i      (take),
      .stk_full_i  (stk_full),
      .stk_empty_i (stk_empty),
      .stk_top_i   (stk_top),
      .next_pc_o   (next_pc),
      .ret_addr_o  (ret_addr),
      .push_o      (push),
      .pop_o       (pop),
      .set_halt_o  (set_halt),
      .set_ovf_o   (set_ovf),
      .set_unf_o   (set_unf)
   );

   nia_ret_stack #(.AW(AW), .DEPTH(DEPTH), .CLEAR_MEM(CLEAR_STACK_MEM)) u_stk (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (ret_addr),
      .top_o       (stk_top),
      .full_o      (stk_full),
      .empty_o     (stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= '0;
         halted_q <= 1'b0;
         ovf_q    <= 1'b0;
         unf_q    <= 1'b0;
      end else begin
         pc_q     <= next_pc;
         halted_q <= halted_q | set_halt;
         ovf_q    <= ovf_q | set_ovf;
         unf_q    <= unf_q | set_unf;
      end
   end

   assign pc_o      = pc_q;
   assign halted_o  = halted_q;
   assign stk_ovf_o = ovf_q;
   assign stk_unf_o = unf_q;

   // R2: a step advances the PC by one
   p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_o && cmd_i == CMD_STEP) |=> pc_o == AW'($past(pc_o) + AW'(1)));

   // R3: a jump lands on the target
   p_jump_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_o && cmd_i == CMD_JUMP) |=> pc_o == $past(tgt_i));

   // R5: a call that fits lands on the target
   p_call_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_o && cmd_i == CMD_CALL && !stk_full) |=> pc_o == $past(tgt_i));

   // R7: once halted, the PC and the halt state are frozen
   p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> ($stable(pc_o) && halted_o));

   // R8: the overflow flag is sticky
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf_o |=> stk_ovf_o);

   // R9: the underflow flag is sticky
   p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stk_unf_o |=> stk_unf_o);

endmodule

// File: tb/nia_unit_tb.sv
module nia_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic [9:0] tgt = '0;
   logic [1:0] cond = '0;
   logic       fz = 1'b0;
   logic       fc = 1'b0;
   logic [9:0] pc;
   logic       halted, ovf, unf;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nia_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .tgt_i(tgt), .cond_i(cond),
      .flag_z_i(fz), .flag_c_i(fc), .pc_o(pc), .halted_o(halted),
      .stk_ovf_o(ovf), .stk_unf_o(unf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive on the falling edge, let one rising edge pass, sample on the next falling edge
   task automatic issue(input logic [2:0] c, input logic [9:0] t,
                        input logic [1:0] cd, input logic z, input logic cy);
      cmd = c; tgt = t; cond = cd; fz = z; fc = cy;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd = 3'd0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 pc", int'(pc), 0);
      chk("R1 halted", int'(halted), 0);
      chk("R1 ovf", int'(ovf), 0);
      chk("R1 unf", int'(unf), 0);
   endtask

   task automatic t_step();
      do_reset();
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      chk("R2 step x3", int'(pc), 3);
      issue(3'd6, 10'd500, 2'd0, 0, 0);
      chk("R2 code6", int'(pc), 4);
      issue(3'd7, 10'd500, 2'd0, 0, 0);
      chk("R2 code7", int'(pc), 5);
      issue(3'd1, 10'd1023, 2'd0, 0, 0);
      chk("R3 jump 1023", int'(pc), 1023);
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      chk("R2 wrap", int'(pc), 0);
   endtask

   task automatic t_jump();
      do_reset();
      issue(3'd1, 10'h155, 2'd0, 0, 0);
      chk("R3 jump", int'(pc), 'h155);
      issue(3'd1, 10'd7, 2'd0, 1, 1);
      chk("R3 jump back", int'(pc), 7);
   endtask

   task automatic t_branch();
      do_reset();
      for (int k = 0; k < 8; k++) begin
         logic [1:0] cd;
         logic       f, taken;
         cd = 2'(k >> 1);
         f  = k[0];
         // 00 zero set, 01 zero clear, 10 carry set, 11 carry clear
         taken = cd[0] ? !f : f;
         issue(3'd1, 10'd100, 2'd0, 0, 0);
         if (cd[1]) issue(3'd2, 10'd500, cd, !f, f);
         else       issue(3'd2, 10'd500, cd, f, !f);
         chk($sformatf("R4 cond=%0d flag=%0d", cd, f), int'(pc), taken ? 500 : 101);
      end
   endtask

   task automatic t_call_ret();
      do_reset();
      issue(3'd1, 10'd10, 2'd0, 0, 0);
      issue(3'd3, 10'd200, 2'd0, 0, 0);
      chk("R5 call 1", int'(pc), 200);
      issue(3'd3, 10'd300, 2'd0, 0, 0);
      chk("R5 call 2", int'(pc), 300);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      chk("R6 ret inner", int'(pc), 201);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      chk("R6 ret outer", int'(pc), 11);
      chk("R9 no unf", int'(unf), 0);
   endtask

   task automatic t_deep();
      int okc;
      do_reset();
      for (int k = 0; k < 16; k++) issue(3'd3, 10'(k * 40 + 5), 2'd0, 0, 0);
      chk("R10 16th call", int'(pc), 605);
      chk("R10 no ovf", int'(ovf), 0);
      issue(3'd3, 10'd900, 2'd0, 0, 0);
      chk("R8 ovf set", int'(ovf), 1);
      chk("R8 pc step", int'(pc), 606);
      okc = 0;
      for (int k = 14; k >= 0; k--) begin
         issue(3'd4, 10'd0, 2'd0, 0, 0);
         if (pc == 10'(k * 40 + 6)) okc++;
      end
      chk("R10 returns 15", okc, 15);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      chk("R10 last ret", int'(pc), 1);
      chk("R9 unf clear", int'(unf), 0);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      chk("R9 unf set", int'(unf), 1);
      chk("R9 pc step", int'(pc), 2);
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      chk("R9 unf sticky", int'(unf), 1);
      chk("R8 ovf sticky", int'(ovf), 1);
   endtask

   task automatic t_halt();
      do_reset();
      issue(3'd1, 10'd77, 2'd0, 0, 0);
      issue(3'd3, 10'd90, 2'd0, 0, 0);
      issue(3'd5, 10'd0, 2'd0, 0, 0);
      chk("R7 halted", int'(halted), 1);
      chk("R7 pc held", int'(pc), 90);
      issue(3'd1, 10'd5, 2'd0, 0, 0);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      issue(3'd2, 10'd6, 2'd0, 1, 0);
      issue(3'd0, 10'd0, 2'd0, 0, 0);
      chk("R7 pc frozen", int'(pc), 90);
      chk("R7 unf frozen", int'(unf), 0);
      do_reset();
      chk("R1 halt cleared", int'(halted), 0);
      issue(3'd4, 10'd0, 2'd0, 0, 0);
      chk("R1 stack emptied", int'(unf), 1);
      chk("R1 pc after unf", int'(pc), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_step();
      t_jump();
      t_branch();
      t_call_ret();
      t_deep();
      t_halt();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule